// File: doc/BRIEF.md
# Memory Ordering Fence Decoder

This block sits in front of a load/store unit and turns a memory-ordering fence instruction word into a compact ordering request. Each 32-bit word arrives on a valid/ready input. The block recognises the memory fence encoding and applies the optional rule that folds device input/output ordering into ordinary read/write ordering. It then reduces the predecessor and successor sets to their read/write parts and emits a 4-bit barrier class. A fence with an empty effective set is reported as a no-op. The total-store-order fence pattern is recognised ahead of the generic decode and has its own class.

The input is valid/ready. `in_ready` is low while reset is asserted and high from the first clock after release. The decoder has no internal stall, so it never applies back-pressure. A word is accepted on any rising edge where `in_valid` and `in_ready` are both high. Exactly one clock after an accepted fence word, the result appears for one cycle with `out_valid` high. The output has no ready, so the consumer must take the result in the cycle it is presented. Words that are not memory fences are accepted and dropped without any output.

Top module: `fence_order_dec`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `out_valid`, `out_barrier`, `out_nop` and `out_tso` are 0 and `out_class` is 0. `in_ready` is 1 from the first rising edge after release.
- R2: A word is decoded only when bits 6:0 equal 0001111 and bits 14:12 equal 000. Any other accepted word produces no `out_valid` pulse.
- R3: For each accepted fence word, `out_valid` is high for exactly the one cycle that follows the accepting edge. Back-to-back words give back-to-back pulses. While `out_valid` is low, `out_barrier`, `out_nop`, `out_tso` and `out_class` are 0.
- R4: Each set is 4 bits, ordered I, O, R, W from MSB to LSB. The predecessor set is bits 27:24 and the successor set is bits 23:20. Let P and S be the effective {R,W} pairs, and define i(R only)=0, i(W only)=1, i(R and W)=2. If both pairs are nonzero, then `out_barrier`=1 and `out_class` = 1 + 3*i(P) + i(S), which gives codes 1 to 9.
- R5: If either effective pair is 00, then `out_nop`=1, `out_barrier`=0 and `out_class`=0.
- R6: When `fiom_en` is 1, each set is adjusted separately: effective R = R|I and effective W = W|O. When `fiom_en` is 0, the I and O bits have no effect on the result.
- R7: The TSO fence is bits 31:28 = 1000, bits 27:24 = 0011 and bits 23:20 = 0011. It yields `out_tso`=1, `out_barrier`=1 and `out_class`=10, whatever bits 19:15 and 11:7 hold.
- R8: Any other value in bits 31:28, and any value in bits 19:15 or 11:7, decodes exactly as the same word with those fields at zero.
- R9: `out_tso` is 0 for every fence word that does not match the R7 pattern, including fm=1000 with other sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can take a word |
| in_instr | input | 32 | Instruction word |
| fiom_en | input | 1 | Fold I into R and O into W |
| out_valid | output | 1 | One-cycle result pulse |
| out_barrier | output | 1 | A barrier is to be issued |
| out_class | output | 4 | Barrier class code (0 none, 1-9 read/write pairs, 10 TSO) |
| out_tso | output | 1 | TSO fence recognised |
| out_nop | output | 1 | Fence with an empty effective set |

## Verification
The bench builds the block with `FOLD_EN=1`. This instantiates the folding logic for both sets, so the `fiom_en` cases are reachable: I-only and O-only sets become barriers or remain no-ops depending on that pin. The vector table covers all nine read/write class combinations, both empty-set cases, the TSO pattern with and without nonzero register fields, and fm=1000 with non-TSO sets. The variant with `FOLD_EN=0`, where `fiom_en` is inert, is not elaborated by the bench.

// File: rtl/fence_dec_pkg.sv
package fence_dec_pkg;
  localparam int INSTR_W  = 32;
  localparam int SET_W    = 4;
  localparam int FM_W     = 4;
  localparam int RW_W     = 2;
  localparam int CLASS_W  = 4;
  localparam int OPC_W    = 7;
  localparam int F3_W     = 3;
  localparam int FM_LSB   = 28;
  localparam int PRED_LSB = 24;
  localparam int SUCC_LSB = 20;
  localparam int F3_LSB   = 12;

  localparam logic [OPC_W-1:0] OPC_MEMORD = 7'b0001111;
  localparam logic [F3_W-1:0]  F3_FENCE   = 3'b000;
  localparam logic [FM_W-1:0]  FM_TSO     = 4'b1000;
  localparam logic [SET_W-1:0] SET_TSO    = 4'b0011;

  // set bit indices (I,O,R,W from MSB)
  localparam int BIT_I = 3;
  localparam int BIT_O = 2;
  localparam int BIT_R = 1;
  localparam int BIT_W = 0;

  typedef enum logic [CLASS_W-1:0] {
    FC_NONE  = 4'd0,
    FC_R_R   = 4'd1,
    FC_R_W   = 4'd2,
    FC_R_RW  = 4'd3,
    FC_W_R   = 4'd4,
    FC_W_W   = 4'd5,
    FC_W_RW  = 4'd6,
    FC_RW_R  = 4'd7,
    FC_RW_W  = 4'd8,
    FC_RW_RW = 4'd9,
    FC_TSO   = 4'd10
  } fclass_e;

  typedef struct packed {
    logic    barrier;
    logic    nop;
    logic    tso;
    fclass_e cls;
  } fresult_t;
endpackage

// File: rtl/fence_field_split.sv
module fence_field_split
  import fence_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               is_fence,
  output logic               is_tso,
  output logic [SET_W-1:0]   pred_set,
  output logic [SET_W-1:0]   succ_set
);
  logic [FM_W-1:0]  fm;
  logic [OPC_W-1:0] opc;
  logic [F3_W-1:0]  f3;

  always_comb begin
    fm       = instr[FM_LSB +: FM_W];
    pred_set = instr[PRED_LSB +: SET_W];
    succ_set = instr[SUCC_LSB +: SET_W];
    opc      = instr[OPC_W-1:0];
    f3       = instr[F3_LSB +: F3_W];
    is_fence = (opc == OPC_MEMORD) && (f3 == F3_FENCE);
    // register fields are deliberately not examined
    is_tso   = is_fence && (fm == FM_TSO) &&
               (pred_set == SET_TSO) && (succ_set == SET_TSO);
  end
endmodule

// File: rtl/fence_set_fold.sv
module fence_set_fold
  import fence_dec_pkg::*;
#(
  parameter bit FOLD_EN = 1'b1
) (
  input  logic [SET_W-1:0] set_in,
  input  logic             fiom,
  output logic [RW_W-1:0]  rw_out
);
  generate
    if (FOLD_EN) begin : g_fold
      always_comb begin
        rw_out[1] = set_in[BIT_R] | (fiom & set_in[BIT_I]);
        rw_out[0] = set_in[BIT_W] | (fiom & set_in[BIT_O]);
      end
    end else begin : g_nofold
      logic unused_fold;
      always_comb begin
        rw_out      = {set_in[BIT_R], set_in[BIT_W]};
        unused_fold = fiom ^ set_in[BIT_I] ^ set_in[BIT_O];
      end
    end
  endgenerate
endmodule

// File: rtl/fence_class_enc.sv
module fence_class_enc
  import fence_dec_pkg::*;
(
  input  logic [RW_W-1:0] pred_rw,
  input  logic [RW_W-1:0] succ_rw,
  input  logic            tso,
  output fresult_t        res
);
  function automatic logic [CLASS_W-1:0] side_rank(input logic [RW_W-1:0] rw);
    case (rw)
      2'b10:   side_rank = 4'd0;
      2'b01:   side_rank = 4'd1;
      default: side_rank = 4'd2;
    endcase
  endfunction

  logic                 empty;
  logic [CLASS_W-1:0]   code;

  always_comb begin
    empty = (pred_rw == '0) || (succ_rw == '0);
    code  = 4'd1 + 4'd3 * side_rank(pred_rw) + side_rank(succ_rw);
    res   = '0;
    if (tso) begin
      res.barrier = 1'b1;
      res.tso     = 1'b1;
      res.cls     = FC_TSO;
    end else if (empty) begin
      res.nop     = 1'b1;
      res.cls     = FC_NONE;
    end else begin
      res.barrier = 1'b1;
      res.cls     = fclass_e'(code);
    end
  end
endmodule

// File: rtl/fence_order_dec.sv
module fence_order_dec
  import fence_dec_pkg::*;
#(
  parameter bit FOLD_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               fiom_en,
  output logic               out_valid,
  output logic               out_barrier,
  output logic [CLASS_W-1:0] out_class,
  output logic               out_tso,
  output logic               out_nop
);
  localparam int NSETS = 2;

  logic                   is_fence, is_tso;
  logic [SET_W-1:0]       sets  [NSETS];
  logic [RW_W-1:0]        rw    [NSETS];
  fresult_t               dec_res, res_q;
  logic                   ready_q, valid_q, take;

  fence_field_split u_split (
    .instr    (in_instr),
    .is_fence (is_fence),
    .is_tso   (is_tso),
    .pred_set (sets[0]),
    .succ_set (sets[1])
  );

  generate
    for (genvar g = 0; g < NSETS; g++) begin : g_side
      fence_set_fold #(.FOLD_EN(FOLD_EN)) u_fold (
        .set_in (sets[g]),
        .fiom   (fiom_en),
        .rw_out (rw[g])
      );
    end
  endgenerate

  fence_class_enc u_enc (
    .pred_rw (rw[0]),
    .succ_rw (rw[1]),
    .tso     (is_tso),
    .res     (dec_res)
  );

  assign take = in_valid && ready_q && is_fence;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= take;
      res_q   <= take ? dec_res : '0;
    end
  end

  assign in_ready    = ready_q;
  assign out_valid   = valid_q;
  assign out_barrier = res_q.barrier;
  assign out_nop     = res_q.nop;
  assign out_tso     = res_q.tso;
  assign out_class   = res_q.cls;

  // R3
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready &&
                        in_instr[OPC_W-1:0] == OPC_MEMORD &&
                        in_instr[F3_LSB +: F3_W] == F3_FENCE));
  // R2
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[OPC_W-1:0] != OPC_MEMORD) |=> !out_valid);
  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_barrier && !out_nop && !out_tso && out_class == '0));
  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nop != out_barrier));
  // R5
  nop_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_nop |-> (out_class == FC_NONE));
  // R7
  tso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tso |-> (out_barrier && out_class == FC_TSO));
  // R4
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_barrier && !out_tso) |-> (out_class >= 4'd1 && out_class <= 4'd9));
endmodule

// File: tb/tb_fence_order_dec.sv
module tb_fence_order_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        fiom_en = 1'b0;
  logic        out_valid, out_barrier, out_tso, out_nop;
  logic [3:0]  out_class;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fence_order_dec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .fiom_en(fiom_en), .out_valid(out_valid),
    .out_barrier(out_barrier), .out_class(out_class), .out_tso(out_tso),
    .out_nop(out_nop)
  );

  // {fm, pred, succ, rs1, rd, fiom, exp_bar, exp_nop, exp_tso, exp_cls}
  localparam int NV = 20;
  localparam logic [29:0] TBL [NV] = '{
    {4'h0, 4'b0011, 4'b0011, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd9},
    {4'h0, 4'b0010, 4'b0010, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd1},
    {4'h0, 4'b0010, 4'b0001, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
    {4'h0, 4'b0010, 4'b0011, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd3},
    {4'h0, 4'b0001, 4'b0010, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd4},
    {4'h0, 4'b0001, 4'b0001, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
    {4'h0, 4'b0001, 4'b0011, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd6},
    {4'h0, 4'b0011, 4'b0010, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
    {4'h0, 4'b0011, 4'b0001, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd8},
    {4'h0, 4'b0000, 4'b0011, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 4'd0},
    {4'h0, 4'b0011, 4'b0000, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 4'd0},
    {4'h0, 4'b1000, 4'b0100, 5'd0,  5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 4'd0},
    {4'h0, 4'b1000, 4'b0100, 5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 4'd2},
    {4'h0, 4'b1100, 4'b1111, 5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 4'd9},
    {4'h0, 4'b0100, 4'b0010, 5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
    {4'h8, 4'b0011, 4'b0011, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 4'd10},
    {4'h8, 4'b0011, 4'b0011, 5'd5,  5'd7,  1'b0, 1'b1, 1'b0, 1'b1, 4'd10},
    {4'h8, 4'b0011, 4'b0010, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 4'd7},
    {4'hF, 4'b0010, 4'b0001, 5'd31, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
    {4'h0, 4'b0011, 4'b0011, 5'd3,  5'd9,  1'b0, 1'b1, 1'b0, 1'b0, 4'd9}
  };

  function automatic logic [31:0] mk(input logic [3:0] fm, input logic [3:0] p,
                                     input logic [3:0] s, input logic [4:0] r1,
                                     input logic [4:0] rd);
    return {fm, p, s, r1, 3'b000, rd, 7'b0001111};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk(tag, "out_valid idle", out_valid, 0);
    chk(tag, "flags idle", {out_barrier, out_nop, out_tso, out_class}, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", in_ready, 0);
    chk_quiet("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after release", in_ready, 1);
    chk_quiet("R1");

    // vector table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = TBL[i];
      in_instr = mk(v[29:26], v[25:22], v[21:18], v[17:13], v[12:8]);
      fiom_en  = v[7];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R3", $sformatf("vec%0d valid", i), out_valid, 1);
      chk("R4", $sformatf("vec%0d class", i), out_class, v[3:0]);
      chk("R5", $sformatf("vec%0d barrier", i), out_barrier, v[6]);
      chk("R5", $sformatf("vec%0d nop", i), out_nop, v[5]);
      chk("R9", $sformatf("vec%0d tso", i), out_tso, v[4]);
      @(negedge clk);
      chk("R3", $sformatf("vec%0d pulse ends", i), out_valid, 0);
    end
    fiom_en = 1'b0;

    // R2: other opcode with a fence-like upper half
    in_instr = {4'h0, 4'b0011, 4'b0011, 5'd0, 3'b000, 5'd0, 7'b0010011};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_quiet("R2");

    // R2: right opcode, funct3 001
    in_instr = {4'h0, 4'b0011, 4'b0011, 5'd0, 3'b001, 5'd0, 7'b0001111};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_quiet("R2");

    // R3: in_valid low does nothing
    in_instr = mk(4'h0, 4'b0011, 4'b0011, 5'd0, 5'd0);
    @(negedge clk);
    chk_quiet("R3");

    // R3: back-to-back words
    in_valid = 1'b1;
    in_instr = mk(4'h0, 4'b0010, 4'b0010, 5'd0, 5'd0);
    @(negedge clk);
    chk("R3", "b2b first valid", out_valid, 1);
    chk("R3", "b2b first class", out_class, 1);
    in_instr = mk(4'h8, 4'b0011, 4'b0011, 5'd0, 5'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3", "b2b second valid", out_valid, 1);
    chk("R7", "b2b second tso", out_tso, 1);
    chk("R7", "b2b second class", out_class, 10);
    @(negedge clk);
    chk_quiet("R3");

    // R6: fold disabled, I/O-only sets give nop
    fiom_en  = 1'b0;
    in_instr = mk(4'h0, 4'b1100, 4'b1100, 5'd0, 5'd0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6", "io only nop", out_nop, 1);
    chk("R6", "io only class", out_class, 0);

    // R1: reset in mid-stream clears outputs
    in_instr = mk(4'h0, 4'b0011, 4'b0011, 5'd0, 5'd0);
    in_valid = 1'b1;
    rst_n    = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "in_ready in re-reset", in_ready, 0);
    chk_quiet("R1");
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule